// File: doc/BRIEF.md
# IO Bank Freeze/Thaw Sequencer

This block walks the control lines of one ordinary IO bank between a frozen state, where the pads are parked in a safe condition, and a thawed state, where they operate normally. Each transition is an ordered series of steps, and consecutive steps are separated by a minimum gap. The gap is a parameter that counts clock cycles, so a 20 ns minimum at 100 MHz becomes a gap of 2 cycles.

The freeze series has two steps. It first parks the drive-related lines: slew enable, weak pull-up and tristate control. After the gap it drops bus-hold and the configuration-done line. The thaw series has three steps and runs in a different order. It first restores bus-hold and configuration-done. After one gap it releases weak pull-up and tristate control. After a second gap it releases slew enable as the last step.

The block is driven by two single-cycle request pulses, one for freeze and one for thaw. It reports a frozen flag and a busy flag. Requests that arrive during a series are dropped. A request for the state the bank is already in completes at once and changes nothing.

Top module: `ioFreezeSeq`

## Requirements
- R1: While reset is held, and once it is released, the five control lines are 0, frozen is 1 and busy is 0.
- R2: The clock edge that samples an accepted freeze request drives slewEnN, pullEnN and triN to 0 together. holdN and cfgDone keep their values at that edge.
- R3: GAP cycles after the first freeze step, holdN and cfgDone go to 0 together and frozen goes to 1. No control line changes between the two steps.
- R4: The clock edge that samples an accepted thaw request drives holdN and cfgDone to 1 together. The other lines keep their values at that edge.
- R5: GAP cycles after the first thaw step, pullEnN and triN go to 1 together.
- R6: GAP cycles after the second thaw step, slewEnN goes to 1 and frozen goes to 0. This is the final step of the thaw.
- R7: busy is 1 from the cycle after an accepted request until the final step is applied. That is exactly GAP cycles for a freeze and 2*GAP cycles for a thaw.
- R8: Freeze or thaw requests sampled while busy is 1 are dropped. The running series continues unchanged, and no further series follows it.
- R9: A freeze request while frozen is 1, or a thaw request while frozen is 0, changes no output and leaves busy at 0.
- R10: When freeze and thaw requests are sampled in the same cycle while idle, the freeze request is acted on and the thaw request is dropped.
- R11: pullEnN always equals triN, and holdN always equals cfgDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| freezeReq | input | 1 | Freeze request pulse |
| thawReq | input | 1 | Thaw request pulse |
| slewEnN | output | 1 | Slew enable, active low |
| pullEnN | output | 1 | Weak pull-up enable, active low |
| triN | output | 1 | Tristate control, active low |
| holdN | output | 1 | Bus-hold control, active low |
| cfgDone | output | 1 | Configuration done, active high |
| frozen | output | 1 | 1 when the bank is frozen |
| busy | output | 1 | 1 while a series is in progress |

## Verification
The assertions check the following on every cycle:
- the paired lines (pullEnN with triN, holdN with cfgDone) always stay equal;
- bus-hold drops only after the drive lines are already low;
- slew rises only after bus-hold and pull-up have been restored;
- any step in the middle of a series comes at least GAP cycles after the step before it;
- frozen changes only at the cycle where busy falls.

The exact cycle of each step is shown only by the bench scenarios. The same holds for the dropping of stray requests at every offset inside a series, same-state requests, and the choice made when both requests arrive together.

// File: rtl/ioFreezePkg.sv
package ioFreezePkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_FRZ_WAIT = 2'd1,
    ST_THW_WAIT1 = 2'd2,
    ST_THW_WAIT2 = 2'd3
  } seqStateT;

  // one strobe per step of the two series
  typedef struct packed {
    logic frzDrive;
    logic frzHold;
    logic thwHold;
    logic thwPull;
    logic thwSlew;
  } stepStrobeT;

endpackage

// File: rtl/ioGapTimer.sv
module ioGapTimer #(
  parameter int GAP = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  output logic gapDone
);
  localparam int CW = (GAP < 2) ? 1 : $clog2(GAP + 1);
  localparam logic [CW-1:0] LOADVAL = CW'(GAP - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= LOADVAL;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign gapDone = (cnt == '0);
endmodule

// File: rtl/ioFreezeCtrl.sv
module ioFreezeCtrl
  import ioFreezePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       freezeReq,
  input  logic       thawReq,
  input  logic       frozenNow,
  input  logic       gapDone,
  output stepStrobeT strobe,
  output logic       gapLoad,
  output logic       busy
);
  seqStateT state, stateNext;

  always_comb begin
    strobe    = '0;
    gapLoad   = 1'b0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        // freeze request takes priority over a simultaneous thaw request
        if (freezeReq) begin
          if (!frozenNow) begin
            strobe.frzDrive = 1'b1;
            gapLoad         = 1'b1;
            stateNext       = ST_FRZ_WAIT;
          end
        end else if (thawReq && frozenNow) begin
          strobe.thwHold = 1'b1;
          gapLoad        = 1'b1;
          stateNext      = ST_THW_WAIT1;
        end
      end
      ST_FRZ_WAIT: begin
        if (gapDone) begin
          strobe.frzHold = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      ST_THW_WAIT1: begin
        if (gapDone) begin
          strobe.thwPull = 1'b1;
          gapLoad        = 1'b1;
          stateNext      = ST_THW_WAIT2;
        end
      end
      ST_THW_WAIT2: begin
        if (gapDone) begin
          strobe.thwSlew = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/ioFreezeDatapath.sv
module ioFreezeDatapath
  import ioFreezePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  stepStrobeT strobe,
  output logic       slewEnN,
  output logic       pullEnN,
  output logic       triN,
  output logic       holdN,
  output logic       cfgDone,
  output logic       frozen
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slewEnN <= 1'b0;
      pullEnN <= 1'b0;
      triN    <= 1'b0;
      holdN   <= 1'b0;
      cfgDone <= 1'b0;
      frozen  <= 1'b1;
    end else begin
      if (strobe.frzDrive) begin
        slewEnN <= 1'b0;
        pullEnN <= 1'b0;
        triN    <= 1'b0;
      end
      if (strobe.frzHold) begin
        holdN   <= 1'b0;
        cfgDone <= 1'b0;
        frozen  <= 1'b1;
      end
      if (strobe.thwHold) begin
        holdN   <= 1'b1;
        cfgDone <= 1'b1;
      end
      if (strobe.thwPull) begin
        pullEnN <= 1'b1;
        triN    <= 1'b1;
      end
      if (strobe.thwSlew) begin
        slewEnN <= 1'b1;
        frozen  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ioFreezeSeq.sv
module ioFreezeSeq
  import ioFreezePkg::*;
#(
  parameter int GAP = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic freezeReq,
  input  logic thawReq,
  output logic slewEnN,
  output logic pullEnN,
  output logic triN,
  output logic holdN,
  output logic cfgDone,
  output logic frozen,
  output logic busy
);
  stepStrobeT strobe;
  logic       gapLoad;
  logic       gapDone;

  ioFreezeCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .freezeReq (freezeReq),
    .thawReq   (thawReq),
    .frozenNow (frozen),
    .gapDone   (gapDone),
    .strobe    (strobe),
    .gapLoad   (gapLoad),
    .busy      (busy)
  );

  ioGapTimer #(.GAP(GAP)) uGap (
    .clk     (clk),
    .rstN    (rstN),
    .load    (gapLoad),
    .gapDone (gapDone)
  );

  ioFreezeDatapath uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .slewEnN (slewEnN),
    .pullEnN (pullEnN),
    .triN    (triN),
    .holdN   (holdN),
    .cfgDone (cfgDone),
    .frozen  (frozen)
  );
endmodule

// File: rtl/ioFreezeChk.sv
module ioFreezeChk #(
  parameter int GAP = 2
) (
  input logic clk,
  input logic rstN,
  input logic freezeReq,
  input logic thawReq,
  input logic slewEnN,
  input logic pullEnN,
  input logic triN,
  input logic holdN,
  input logic cfgDone,
  input logic frozen,
  input logic busy
);
  logic [4:0] lineVec, lastVec;
  logic       lastBusy;
  int         since;

  assign lineVec = {slewEnN, pullEnN, triN, holdN, cfgDone};

  // cycles since the control lines last changed, saturating at GAP
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastVec  <= 5'b0;
      lastBusy <= 1'b0;
      since    <= GAP;
    end else begin
      lastVec  <= lineVec;
      lastBusy <= busy;
      if (lineVec != lastVec) since <= 1;
      else if (since < GAP)   since <= since + 1;
    end
  end

  a_r11_pairs: assert property (@(posedge clk) disable iff (!rstN)
    (pullEnN == triN) && (holdN == cfgDone));

  a_r3_hold_after_drive: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdN) |-> ($past(slewEnN) == 1'b0 && $past(triN) == 1'b0));

  a_r5_pull_after_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pullEnN) |-> $past(holdN) == 1'b1);

  a_r6_slew_last: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slewEnN) |-> ($past(holdN) && $past(pullEnN)));

  a_r3_min_gap: assert property (@(posedge clk) disable iff (!rstN)
    ((lineVec != lastVec) && lastBusy) |-> (since >= GAP));

  a_r7_frozen_at_end: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(frozen) |-> $fell(busy));

  a_r8_busy_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(freezeReq || thawReq));
endmodule

bind ioFreezeSeq ioFreezeChk #(.GAP(GAP)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .freezeReq (freezeReq),
  .thawReq   (thawReq),
  .slewEnN   (slewEnN),
  .pullEnN   (pullEnN),
  .triN      (triN),
  .holdN     (holdN),
  .cfgDone   (cfgDone),
  .frozen    (frozen),
  .busy      (busy)
);

// File: tb/sim_ioFreezeSeq.sv
`timescale 1ns/1ps
module sim_ioFreezeSeq;
  localparam int GAP = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic freezeReq = 1'b0;
  logic thawReq = 1'b0;
  logic slewEnN, pullEnN, triN, holdN, cfgDone, frozen, busy;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ioFreezeSeq #(.GAP(GAP)) u0 (
    .clk(clk), .rstN(rstN), .freezeReq(freezeReq), .thawReq(thawReq),
    .slewEnN(slewEnN), .pullEnN(pullEnN), .triN(triN), .holdN(holdN),
    .cfgDone(cfgDone), .frozen(frozen), .busy(busy)
  );

  // vector order: slewEnN pullEnN triN holdN cfgDone frozen busy
  function automatic logic [6:0] expFreeze(int t);
    if (t < GAP) return 7'b0001101;
    return 7'b0000010;
  endfunction

  function automatic logic [6:0] expThaw(int t);
    if (t < GAP)     return 7'b0001111;
    if (t < 2 * GAP) return 7'b0111111;
    return 7'b1111100;
  endfunction

  function automatic string tagFreeze(int t);
    if (t < GAP) return "R2/R7";
    return "R3/R7";
  endfunction

  function automatic string tagThaw(int t);
    if (t < GAP)     return "R4/R7";
    if (t < 2 * GAP) return "R5/R7";
    return "R6/R7";
  endfunction

  task automatic check(string tag, logic [6:0] exp);
    logic [6:0] act;
    act = {slewEnN, pullEnN, triN, holdN, cfgDone, frozen, busy};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // one series; stray request of kind strayKind (0 freeze, 1 thaw) at offset j (-1 none)
  task automatic runSeries(bit isFreeze, bit both, int j, bit strayKind);
    freezeReq = isFreeze;
    thawReq   = !isFreeze || both;
    @(negedge clk);
    freezeReq = 1'b0;
    thawReq   = 1'b0;
    for (int t = 0; t <= 2 * GAP + 1; t++) begin
      string tag;
      tag = isFreeze ? tagFreeze(t) : tagThaw(t);
      if (j >= 0) tag = {tag, "/R8"};
      if (both) tag = {tag, "/R10"};
      check(tag, isFreeze ? expFreeze(t) : expThaw(t));
      freezeReq = (t == j) && !strayKind;
      thawReq   = (t == j) && strayKind;
      @(negedge clk);
    end
    freezeReq = 1'b0;
    thawReq   = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 7'b0000010);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", 7'b0000010);

    // R9: freeze while frozen
    freezeReq = 1'b1;
    @(negedge clk);
    freezeReq = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check("R9 freeze while frozen", 7'b0000010);
      @(negedge clk);
    end

    // plain thaw then plain freeze
    runSeries(1'b0, 1'b0, -1, 1'b0);

    // R9: thaw while thawed
    thawReq = 1'b1;
    @(negedge clk);
    thawReq = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check("R9 thaw while thawed", 7'b1111100);
      @(negedge clk);
    end

    runSeries(1'b1, 1'b0, -1, 1'b0);

    // R8 sweep: stray request at every busy offset, both kinds
    for (int s = 0; s < 2; s++) begin
      for (int j = 0; j < 2 * GAP; j++) begin
        runSeries(1'b0, 1'b0, j, s[0]);
        if (j < GAP) runSeries(1'b1, 1'b0, j, s[0]);
        else         runSeries(1'b1, 1'b0, -1, 1'b0);
      end
    end

    // R10: both requests together while thawed
    runSeries(1'b0, 1'b0, -1, 1'b0);
    runSeries(1'b1, 1'b1, -1, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule